// File: doc/BRIEF.md
# Disk Arm Seek Responder

This block sits on the drive side of a disk controller link. It answers each step request from the controller with a ready handshake paced like a real actuator, and it keeps the current cylinder number. The request arrives as an active-low level. The controller holds it low until ready drops, then releases it. The controller asserts it again almost at once after ready comes back.

The request passes through a multi-flop synchronizer and a debounce filter. The direction and step-size inputs are synchronized as well. They are sampled only while the filtered request is high, and the sampled pair is frozen into the active step when that step starts. After a step starts, ready stays high for a first delay, which differs for one-cylinder and two-cylinder steps. Ready then goes low for a fixed settle time. When ready returns high, the new cylinder number is committed, clamped to the range 0 to a parameter maximum. The block is armed for the next request in the same cycle.

Top module: `seek_responder`

## Requirements
- R1: After reset, `ready` is 1 and `cyl_pos` is 0.
- R2: `ready` goes low exactly SYNC_STAGES + DEB_CYCLES + 1 + D cycles after `step_req_n` falls. D is FALL1_CYC when the captured size is 0 (one cylinder) and FALL2_CYC when it is 1 (two cylinders).
- R3: Once low, `ready` stays low for exactly SETTLE_CYC cycles and then returns to 1.
- R4: `cyl_pos` changes only in the cycle `ready` rises, by the step amount. `dir_up` = 1 adds to the position and 0 subtracts. `big_step` = 1 moves two cylinders and 0 moves one.
- R5: Direction and size are taken only while the filtered request is high. Changes made while the request is low or while a step is in flight do not affect that step.
- R6: The committed position saturates at 0 when moving down and at CYL_MAX when moving up.
- R7: A request driven low in the same cycle that `ready` is seen high again is accepted with the R2 latency.
- R8: A step starts only if the filtered request was high after the previous start. A request held low across the return of `ready` produces no second step.
- R9: A low pulse on `step_req_n` shorter than DEB_CYCLES clock cycles starts no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req_n | input | 1 | Active-low step request level from the controller |
| dir_up | input | 1 | Step direction: 1 increases the cylinder number |
| big_step | input | 1 | Step size: 1 means two cylinders, 0 means one |
| ready | output | 1 | High when a step request can be accepted |
| cyl_pos | output | $clog2(CYL_MAX+1) | Current cylinder number |

## Verification
The bench times every ready fall and rise against the request edge to the exact cycle, for both step sizes. A design that used the wrong delay, or measured from the wrong edge, would be off by a cycle or more. It flips direction and size while a step is in flight and checks that the position still moves the way the captured values say. A design that did not freeze them would land on a different cylinder. It also holds the request low across the return of ready, sends a request in the very cycle ready returns, fires a sub-debounce glitch, and drives the position into both clamps. These catch, in turn, a design that double-steps, one that misses the fast re-request, one that reacts to noise, and one that wraps the cylinder count.

// File: rtl/seek_pkg.sv
package seek_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCEL  = 2'd1,
      ST_SETTLE = 2'd2
   } seek_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/seek_sync_filter.sv
module seek_sync_filter #(
   parameter int STAGES  = 2,
   parameter int HOLD    = 3,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("seek_sync_filter: STAGES must be at least 2");
   end
   if (HOLD < 0) begin : g_bad_hold
      $error("seek_sync_filter: HOLD must not be negative");
   end

   logic [STAGES-1:0] chain_q;
   logic              s;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign s = chain_q[STAGES-1];

   if (HOLD == 0) begin : g_bypass
      assign dout = s;
   end else begin : g_deb
      localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
      logic [CW-1:0] cnt_q;
      logic          filt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= RST_VAL;
         end else if (s == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(HOLD - 1)) begin
            cnt_q  <= '0;
            filt_q <= s;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign dout = filt_q;

      // R9: the filtered level moves only to a value the synchronizer was presenting
      p_deb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt_q) |-> ($past(s) == filt_q));
   end

endmodule

// File: rtl/seek_pos_track.sv
module seek_pos_track #(
   parameter int CYL_MAX = 202,
   parameter int CYL_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             up,
   input  logic             two,
   output logic [CYL_W-1:0] pos
);

   logic [CYL_W:0]   amt;
   logic [CYL_W:0]   wide_up;
   logic [CYL_W:0]   wide_dn;
   logic [CYL_W-1:0] nxt;

   always_comb begin
      amt     = two ? (CYL_W+1)'(2) : (CYL_W+1)'(1);
      wide_up = {1'b0, pos} + amt;
      wide_dn = {1'b0, pos} - amt;
      if (up) begin
         nxt = (wide_up > (CYL_W+1)'(CYL_MAX)) ? CYL_W'(CYL_MAX) : wide_up[CYL_W-1:0];
      end else begin
         nxt = ({1'b0, pos} < amt) ? '0 : wide_dn[CYL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      pos <= '0;
      else if (commit) pos <= nxt;
   end

   p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pos) <= CYL_MAX);

   p_pos_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(pos));

   p_pos_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ((int'($past(pos)) - int'(pos) <= 2) && (int'(pos) - int'($past(pos)) <= 2)));

endmodule

// File: rtl/seek_responder.sv
module seek_responder
   import seek_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4,
   parameter int FALL1_CYC   = 1_000_000,
   parameter int FALL2_CYC   = 1_250_000,
   parameter int SETTLE_CYC  = 2_500_000,
   parameter int CYL_MAX     = 202,
   localparam int CYL_W      = $clog2(CYL_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_req_n,
   input  logic             dir_up,
   input  logic             big_step,
   output logic             ready,
   output logic [CYL_W-1:0] cyl_pos
);

   localparam int MAX_D = max3(FALL1_CYC, FALL2_CYC, SETTLE_CYC);
   localparam int CNT_W = $clog2(MAX_D + 1);

   if (FALL1_CYC < 1 || FALL2_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_delay
      $error("seek_responder: every phase delay must be at least one cycle");
   end
   if (CYL_MAX < 1) begin : g_bad_max
      $error("seek_responder: CYL_MAX must be at least 1");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("seek_responder: request debounce needs at least one cycle");
   end

   logic req_f, dir_s, big_s;

   seek_sync_filter #(.STAGES(SYNC_STAGES), .HOLD(DEB_CYCLES), .RST_VAL(1'b1)) u_req (
      .clk(clk), .rst_n(rst_n), .din(step_req_n), .dout(req_f));
   seek_sync_filter #(.STAGES(SYNC_STAGES), .HOLD(0), .RST_VAL(1'b0)) u_dir (
      .clk(clk), .rst_n(rst_n), .din(dir_up), .dout(dir_s));
   seek_sync_filter #(.STAGES(SYNC_STAGES), .HOLD(0), .RST_VAL(1'b0)) u_size (
      .clk(clk), .rst_n(rst_n), .din(big_step), .dout(big_s));

   seek_state_t      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             stg_dir_q, stg_big_q;
   logic             act_dir_q, act_big_q;
   logic             commit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         armed_q   <= 1'b0;
         stg_dir_q <= 1'b0;
         stg_big_q <= 1'b0;
         act_dir_q <= 1'b0;
         act_big_q <= 1'b0;
      end else begin
         if (req_f) begin
            armed_q   <= 1'b1;
            stg_dir_q <= dir_s;
            stg_big_q <= big_s;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (!req_f && armed_q) begin
                  state_q   <= ST_ACCEL;
                  armed_q   <= 1'b0;
                  act_dir_q <= stg_dir_q;
                  act_big_q <= stg_big_q;
                  cnt_q     <= stg_big_q ? CNT_W'(FALL2_CYC - 1) : CNT_W'(FALL1_CYC - 1);
               end
            end
            ST_ACCEL: begin
               if (cnt_q == '0) begin
                  state_q <= ST_SETTLE;
                  cnt_q   <= CNT_W'(SETTLE_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_SETTLE: begin
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign commit = (state_q == ST_SETTLE) && (cnt_q == '0);
   assign ready  = (state_q != ST_SETTLE);

   seek_pos_track #(.CYL_MAX(CYL_MAX), .CYL_W(CYL_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .up(act_dir_q), .two(act_big_q), .pos(cyl_pos));

   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> ($stable(act_dir_q) && $stable(act_big_q)));

   p_fall_after_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> ($past(state_q) == ST_ACCEL && $past(cnt_q) == '0));

   p_start_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACCEL && $past(state_q) == ST_IDLE) |-> ($past(armed_q) && !$past(req_f)));

   p_rise_commits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(commit));

endmodule

// File: tb/tb_seek_responder.sv
module tb_seek_responder;

   localparam int S     = 2;
   localparam int DEB   = 3;
   localparam int F1    = 20;
   localparam int F2    = 32;
   localparam int LW    = 40;
   localparam int MAXC  = 5;
   localparam int PW    = $clog2(MAXC + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_n = 1'b1;
   logic dir = 1'b0;
   logic big = 1'b0;
   logic ready;
   logic [PW-1:0] cyl_pos;

   always #2 clk = ~clk;   // 250 MHz

   seek_responder #(.SYNC_STAGES(S), .DEB_CYCLES(DEB), .FALL1_CYC(F1), .FALL2_CYC(F2),
                    .SETTLE_CYC(LW), .CYL_MAX(MAXC)) dut (
      .clk(clk), .rst_n(rst_n), .step_req_n(req_n), .dir_up(dir), .big_step(big),
      .ready(ready), .cyl_pos(cyl_pos));

   typedef struct { longint t_req; int dly; int pos; } exp_t;
   exp_t exp_q[$];

   int     n_tests = 0;
   int     n_fail  = 0;
   longint cyc     = 0;
   int     model_pos = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor: pops expected items on ready edges
   logic   prev_rdy = 1'b1;
   longint t_fall = 0;
   exp_t   cur;
   bit     have_cur = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_rdy && !ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 R9 unexpected step", 1, 0);
               have_cur = 1'b0;
            end else begin
               cur = exp_q.pop_front();
               have_cur = 1'b1;
               chk(cyc - cur.t_req == longint'(cur.dly), "R2 fall delay", cyc - cur.t_req, cur.dly);
            end
            t_fall = cyc;
         end
         if (!prev_rdy && ready) begin
            chk(cyc - t_fall == LW, "R3 low time", cyc - t_fall, LW);
            if (have_cur)
               chk(int'(cyl_pos) == cur.pos, "R4 R6 position", cyl_pos, cur.pos);
            have_cur = 1'b0;
         end
      end
      prev_rdy = ready;
   end

   task automatic wait_ready(input logic v);
      do @(negedge clk); while (ready !== v);
   endtask

   task automatic do_step(input bit d, input bit b, input bit quick, input bit tamper, input bit hold);
      exp_t it;
      int amt;
      dir = d;
      big = b;
      if (!quick) repeat (10) @(negedge clk);
      amt = b ? 2 : 1;
      model_pos = d ? model_pos + amt : model_pos - amt;
      if (model_pos > MAXC) model_pos = MAXC;
      if (model_pos < 0)    model_pos = 0;
      it.t_req = cyc;
      it.dly   = S + DEB + 1 + (b ? F2 : F1);
      it.pos   = model_pos;
      exp_q.push_back(it);
      req_n = 1'b0;
      wait_ready(1'b0);
      if (tamper) begin   // R5: changes during the step must not matter
         dir = ~d;
         big = ~b;
      end
      if (hold) begin     // R8: keep request low across the return of ready
         wait_ready(1'b1);
         repeat (60) @(negedge clk);
         chk(ready === 1'b1, "R8 held request restarted", ready, 1);
         chk(int'(cyl_pos) == model_pos, "R8 position after held request", cyl_pos, model_pos);
         req_n = 1'b1;
      end else begin
         repeat (3) @(negedge clk);
         req_n = 1'b1;
         wait_ready(1'b1);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : driver
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready === 1'b1, "R1 ready after reset", ready, 1);
      chk(cyl_pos == '0, "R1 position after reset", cyl_pos, 0);

      do_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // up 1 -> 1
      do_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // up 2 -> 3
      do_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // down 2 -> 1
      do_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // down 2 clamps R6 -> 0
      do_step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // down at 0 stays R6
      do_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // -> 2
      do_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // -> 4
      do_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // clamps at max R6 -> 5
      do_step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);   // R5 tamper in flight -> 4
      do_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);   // R7 immediate re-request -> 2
      do_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);   // R7 again, small step -> 3

      // R9: short glitch on the request
      repeat (10) @(negedge clk);
      req_n = 1'b0;
      repeat (DEB - 1) @(negedge clk);
      req_n = 1'b1;
      repeat (80) @(negedge clk);
      chk(ready === 1'b1, "R9 glitch started a step", ready, 1);
      chk(int'(cyl_pos) == model_pos, "R9 glitch moved position", cyl_pos, model_pos);

      do_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // R8 held low -> 4
      do_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // normal after hold -> 2

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R2 expected steps outstanding", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule